// File: doc/BRIEF.md
# I2C Clock Phase Sequencer

This block produces the serial clock of an I2C master and the timing marks the byte engine needs. A prescaler turns the peripheral clock into an internal tick enable. Each SCL period is counted in these ticks. The period is split into a low phase and a high phase. Within each period the block emits two single-cycle strobes. One marks the middle of the low phase, where the byte engine may change SDA. The other marks the middle of the high phase, where SDA is sampled.

A start request frames a transfer. The block reports the moment for SDA to fall while SCL is still released. It holds that condition for a half period, then begins clocking. The first low phase after a start is lengthened by a programmable setup delay. A stop request is taken at the end of a high phase. One more low phase follows, then SCL is released. The block reports the moment for SDA to rise, and after that it keeps the bus free for another half period. While the block releases SCL in a high phase, counting waits until the pad reads high, so a slave can stretch the clock. Software loads the divider fields, and changes them only while the block is idle.

Top module: `scl_timing_gen`

## Requirements
- R1: `ick_en` pulses for one clock in every 1+CDF clocks, where CDF is `clk_div_cfg[2:0]`.
- R2: With SCGD = `clk_div_cfg[8:3]` and C = `rise_fall_comp`, a period is P = 20 + 8·SCGD + C ticks. The low phase lasts floor(P/2) ticks and the high phase lasts P − floor(P/2) ticks. `scl_drive_low` is 1 exactly during low phases.
- R3: The first low phase after a start lasts `first_bit_setup` + 2 ticks longer than a normal low phase. For example, 15 gives 17 extra ticks.
- R4: `sda_change_stb` pulses on tick floor(L/2) of every low phase, counting the first tick of the phase as 0, where L is the normal low length.
- R5: `sda_sample_stb` pulses on the counted tick floor(H/2) of every high phase, where H is the high length.
- R6: During a high phase or stop setup, a tick on which `scl_pad_in` is 0 is not counted, and every later event moves back by one tick.
- R7: When idle, a tick with `start_req` high pulses `start_stb`. SCL then stays released for H ticks before the first low phase.
- R8: If `stop_req` is high on the last tick of a high phase, one normal low phase follows. SCL is then released, `stop_stb` pulses on the H-th counted tick, and the block stays busy H more ticks before it returns to idle.
- R9: When idle, SCL is released and no strobe fires until a start is taken.
- R10: At most one strobe fires per clock, and only in a clock where `ick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div_cfg | input | 9 | Bits [2:0] prescaler CDF, bits [8:3] period field SCGD |
| rise_fall_comp | input | 4 | Edge compensation ticks added to the period |
| first_bit_setup | input | 4 | Extra first-low-phase delay, minus 2 |
| start_req | input | 1 | Byte engine asks for a start condition |
| stop_req | input | 1 | Byte engine asks for a stop after this bit |
| scl_pad_in | input | 1 | Sampled SCL pad level |
| ick_en | output | 1 | Internal tick enable |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_change_stb | output | 1 | SDA may change now |
| sda_sample_stb | output | 1 | Sample SDA now |
| start_stb | output | 1 | Drive SDA low for the start condition |
| stop_stb | output | 1 | Release SDA for the stop condition |

## Verification
The bench checks three kinds of timing. The first is odd periods, where low and high differ by one tick; a swapped split would move every rise and sample by one tick. The second is the maximum first-bit setup value, where an off-by-two delay mapping would shift the first rise. The third is a stretch inside a high phase; a counter that ran during the stretch would produce its sample strobe early. A start requested during the bus-free interval must wait until the full half period after the stop has passed. A design that returned to idle early would let the start through too soon.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_LOW   = 3'd2,
    PH_HIGH  = 3'd3,
    PH_STOP  = 3'd4,
    PH_FREE  = 3'd5
  } phase_e;

  localparam int unsigned BASE_TICKS = 20;
  localparam int unsigned SCGD_SCALE = 8;
  localparam int unsigned SETUP_BIAS = 2;

  function automatic int unsigned period_ticks(int unsigned scgd, int unsigned comp);
    return BASE_TICKS + SCGD_SCALE * scgd + comp;
  endfunction

  function automatic int unsigned low_ticks(int unsigned period);
    return period / 2;
  endfunction

  function automatic int unsigned high_ticks(int unsigned period);
    return period - (period / 2);
  endfunction

  function automatic int unsigned setup_ticks(int unsigned setup);
    return setup + SETUP_BIAS;
  endfunction

endpackage

// File: rtl/sclgen_prescaler.sv
module sclgen_prescaler #(
  parameter int CDF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CDF_W-1:0] cdf,
  output logic             ick_en
);

  logic [CDF_W-1:0] div_cnt;

  assign ick_en = (div_cnt >= cdf);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (ick_en) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sclgen_period_calc.sv
module sclgen_period_calc
  import sclgen_pkg::*;
#(
  parameter int SCGD_W  = 6,
  parameter int COMP_W  = 4,
  parameter int SETUP_W = 4,
  parameter int CNT_W   = 10
) (
  input  logic [SCGD_W-1:0]  scgd,
  input  logic [COMP_W-1:0]  comp,
  input  logic [SETUP_W-1:0] setup,
  output logic [CNT_W-1:0]   low_len,
  output logic [CNT_W-1:0]   high_len,
  output logic [CNT_W-1:0]   first_extra
);

  int unsigned period_w;

  always_comb begin
    period_w    = period_ticks(32'(scgd), 32'(comp));
    low_len     = CNT_W'(low_ticks(period_w));
    high_len    = CNT_W'(high_ticks(period_w));
    first_extra = CNT_W'(setup_ticks(32'(setup)));
  end

endmodule

// File: rtl/sclgen_phase_ctrl.sv
module sclgen_phase_ctrl
  import sclgen_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ick_en,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] high_len,
  input  logic [CNT_W-1:0] first_extra,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             scl_pad_in,
  output phase_e           phase,
  output logic [CNT_W-1:0] tick,
  output logic             tick_adv,
  output logic             scl_drive_low,
  output logic             sda_change_stb,
  output logic             sda_sample_stb,
  output logic             start_stb,
  output logic             stop_stb
);

  phase_e           phase_q;
  logic [CNT_W-1:0] tick_q;
  logic             first_q;
  logic             stop_q;
  logic [CNT_W-1:0] cur_len;
  logic             stall;
  logic             last_tick;

  always_comb begin
    unique case (phase_q)
      PH_LOW:  cur_len = low_len + (first_q ? first_extra : '0);
      PH_IDLE: cur_len = CNT_W'(1);
      default: cur_len = high_len;
    endcase
  end

  assign stall     = ((phase_q == PH_HIGH) || (phase_q == PH_STOP)) && !scl_pad_in;
  assign tick_adv  = ick_en && !stall && (phase_q != PH_IDLE);
  assign last_tick = (tick_q == cur_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tick_q  <= '0;
      first_q <= 1'b0;
      stop_q  <= 1'b0;
    end else if (phase_q == PH_IDLE) begin
      if (ick_en && start_req) begin
        phase_q <= PH_START;
        tick_q  <= '0;
        stop_q  <= 1'b0;
      end
    end else if (tick_adv) begin
      if (last_tick) begin
        tick_q <= '0;
        unique case (phase_q)
          PH_START: begin
            phase_q <= PH_LOW;
            first_q <= 1'b1;
          end
          PH_LOW: begin
            first_q <= 1'b0;
            phase_q <= stop_q ? PH_STOP : PH_HIGH;
          end
          PH_HIGH: begin
            if (stop_req) stop_q <= 1'b1;
            phase_q <= PH_LOW;
          end
          PH_STOP: phase_q <= PH_FREE;
          default: phase_q <= PH_IDLE;
        endcase
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign phase          = phase_q;
  assign tick           = tick_q;
  assign scl_drive_low  = (phase_q == PH_LOW);
  assign start_stb      = (phase_q == PH_IDLE) && ick_en && start_req;
  assign sda_change_stb = tick_adv && (phase_q == PH_LOW) && (tick_q == (low_len >> 1));
  assign sda_sample_stb = tick_adv && (phase_q == PH_HIGH) && (tick_q == (high_len >> 1));
  assign stop_stb       = tick_adv && (phase_q == PH_STOP) && last_tick;

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import sclgen_pkg::*;
#(
  parameter int CDF_W   = 3,
  parameter int SCGD_W  = 6,
  parameter int COMP_W  = 4,
  parameter int SETUP_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CDF_W+SCGD_W-1:0] clk_div_cfg,
  input  logic [COMP_W-1:0]       rise_fall_comp,
  input  logic [SETUP_W-1:0]      first_bit_setup,
  input  logic                    start_req,
  input  logic                    stop_req,
  input  logic                    scl_pad_in,
  output logic                    ick_en,
  output logic                    scl_drive_low,
  output logic                    sda_change_stb,
  output logic                    sda_sample_stb,
  output logic                    start_stb,
  output logic                    stop_stb
);

  localparam int MAX_PERIOD = 20 + 8 * (2**SCGD_W - 1) + (2**COMP_W - 1);
  localparam int CNT_W      = $clog2(MAX_PERIOD + 2**SETUP_W + 2);

  logic [CDF_W-1:0]  cdf_w;
  logic [SCGD_W-1:0] scgd_w;
  logic [CNT_W-1:0]  low_len_w;
  logic [CNT_W-1:0]  high_len_w;
  logic [CNT_W-1:0]  first_extra_w;
  phase_e            phase_w;
  logic [CNT_W-1:0]  tick_w;
  logic              tick_adv_w;

  assign cdf_w  = clk_div_cfg[CDF_W-1:0];
  assign scgd_w = clk_div_cfg[CDF_W+SCGD_W-1:CDF_W];

  sclgen_prescaler #(.CDF_W(CDF_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .cdf    (cdf_w),
    .ick_en (ick_en)
  );

  sclgen_period_calc #(
    .SCGD_W(SCGD_W), .COMP_W(COMP_W), .SETUP_W(SETUP_W), .CNT_W(CNT_W)
  ) u_calc (
    .scgd        (scgd_w),
    .comp        (rise_fall_comp),
    .setup       (first_bit_setup),
    .low_len     (low_len_w),
    .high_len    (high_len_w),
    .first_extra (first_extra_w)
  );

  sclgen_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .ick_en         (ick_en),
    .low_len        (low_len_w),
    .high_len       (high_len_w),
    .first_extra    (first_extra_w),
    .start_req      (start_req),
    .stop_req       (stop_req),
    .scl_pad_in     (scl_pad_in),
    .phase          (phase_w),
    .tick           (tick_w),
    .tick_adv       (tick_adv_w),
    .scl_drive_low  (scl_drive_low),
    .sda_change_stb (sda_change_stb),
    .sda_sample_stb (sda_sample_stb),
    .start_stb      (start_stb),
    .stop_stb       (stop_stb)
  );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk
  import sclgen_pkg::*;
#(
  parameter int CDF_W = 3,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CDF_W-1:0] cdf,
  input logic             ick_en,
  input phase_e           phase,
  input logic [CNT_W-1:0] tick,
  input logic             tick_adv,
  input logic             start_req,
  input logic             scl_pad_in,
  input logic             scl_drive_low,
  input logic             sda_change_stb,
  input logic             sda_sample_stb,
  input logic             start_stb,
  input logic             stop_stb
);

  // R1
  ick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ick_en && cdf != '0) |=> (!ick_en || cdf == '0));

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sda_change_stb, sda_sample_stb, start_stb, stop_stb}));

  // R10
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_change_stb || sda_sample_stb || start_stb || stop_stb) |-> ick_en);

  // R6
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_HIGH || phase == PH_STOP) && !scl_pad_in) |=> $stable(tick));

  // R6
  stretch_noadv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIGH && !scl_pad_in) |-> !tick_adv);

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !(ick_en && start_req)) |=> (phase == PH_IDLE && !scl_drive_low));

  // R7
  start_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |-> !scl_drive_low);

  // R8
  stop_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |-> (!scl_drive_low && scl_pad_in));

  // R4
  change_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change_stb |-> scl_drive_low);

endmodule

bind scl_timing_gen scl_timing_gen_chk #(.CDF_W(CDF_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cdf            (cdf_w),
  .ick_en         (ick_en),
  .phase          (phase_w),
  .tick           (tick_w),
  .tick_adv       (tick_adv_w),
  .start_req      (start_req),
  .scl_pad_in     (scl_pad_in),
  .scl_drive_low  (scl_drive_low),
  .sda_change_stb (sda_change_stb),
  .sda_sample_stb (sda_sample_stb),
  .start_stb      (start_stb),
  .stop_stb       (stop_stb)
);

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] clk_div_cfg = '0;
  logic [3:0] rise_fall_comp = '0;
  logic [3:0] first_bit_setup = '0;
  logic       start_req = 1'b0;
  logic       stop_req = 1'b0;
  logic       scl_pad_in = 1'b1;
  logic       ick_en, scl_drive_low, sda_change_stb, sda_sample_stb, start_stb, stop_stb;

  always #5 clk = ~clk;

  scl_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .clk_div_cfg(clk_div_cfg),
    .rise_fall_comp(rise_fall_comp), .first_bit_setup(first_bit_setup),
    .start_req(start_req), .stop_req(stop_req), .scl_pad_in(scl_pad_in),
    .ick_en(ick_en), .scl_drive_low(scl_drive_low), .sda_change_stb(sda_change_stb),
    .sda_sample_stb(sda_sample_stb), .start_stb(start_stb), .stop_stb(stop_stb)
  );

  localparam int EV_START = 0, EV_FALL = 1, EV_CHANGE = 2, EV_RISE = 3,
                 EV_SAMPLE = 4, EV_STOP = 5;

  typedef struct { int kind; int rel; string req; } ev_t;
  ev_t exp_q[$];

  int n_checks = 0, n_fail = 0;
  int tk = 0, base_tk = 0, stop_tk = 0;
  int bits_target = 0, samples_seen = 0, rise_count = 0;
  int stretch_bit = -1, stretch_len = 0, stretch_left = 0;
  int chain_gap = -1;
  bit chain_start = 1'b0, prev_low = 1'b0, mon_en = 1'b0;
  int cycles = 0;

  function automatic string ev_name(int k);
    case (k)
      EV_START: return "START";  EV_FALL: return "FALL";
      EV_CHANGE: return "CHANGE"; EV_RISE: return "RISE";
      EV_SAMPLE: return "SAMPLE"; default: return "STOP";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic observe(int kind);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R9", {"unexpected event ", ev_name(kind)}, kind, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind, e.req, "event kind", kind, e.kind);
      check((tk - base_tk) == e.rel, e.req, {ev_name(kind), " tick"}, tk - base_tk, e.rel);
    end
  endtask

  task automatic push(int kind, int rel, string req);
    ev_t e;
    e.kind = kind; e.rel = rel; e.req = req;
    exp_q.push_back(e);
  endtask

  // Expected schedule, written from the requirements in tick units
  task automatic queue_xfer(int scgd, int comp, int setup, int nbits, int sbit, int slen);
    int p, hi, lo, d, pos;
    p  = 20 + scgd * 8 + comp;   // R2
    hi = (p + 1) / 2;
    lo = p - hi;
    d  = setup + 2;              // R3
    push(EV_START, 0, "R7");
    pos = 1 + hi;                // R7 hold
    for (int b = 0; b < nbits; b++) begin
      push(EV_FALL, pos, "R2");
      push(EV_CHANGE, pos + lo / 2, "R4");
      pos += lo + ((b == 0) ? d : 0);
      push(EV_RISE, pos, (b == 0) ? "R3" : "R2");
      if (b == sbit) pos += slen;                    // R6
      push(EV_SAMPLE, pos + hi / 2, (b == sbit) ? "R6" : "R5");
      pos += hi;
    end
    push(EV_FALL, pos, "R8");
    push(EV_CHANGE, pos + lo / 2, "R4");
    pos += lo;
    push(EV_RISE, pos, "R8");
    push(EV_STOP, pos + hi - 1, "R8");
  endtask

  // Monitor: stamps outputs with the index of the coming tick
  always @(negedge clk) begin
    cycles++;
    if (rst_n && mon_en) begin
      if (scl_drive_low != prev_low) begin
        if (!scl_drive_low) begin
          observe(EV_RISE);
          if (rise_count == stretch_bit && stretch_len > 0) stretch_left = stretch_len;
          rise_count++;
        end else begin
          observe(EV_FALL);
          start_req = 1'b0;
        end
        prev_low = scl_drive_low;
      end
      scl_pad_in = (stretch_left == 0) && !scl_drive_low;
      if (ick_en) begin
        if (start_stb) begin
          if (chain_start) begin
            check(tk - stop_tk == chain_gap, "R8", "start after bus free", tk - stop_tk, chain_gap);
            chain_start = 1'b0;
          end
          base_tk = tk; samples_seen = 0; rise_count = 0;
          observe(EV_START);
        end
        if (sda_change_stb) observe(EV_CHANGE);
        if (sda_sample_stb) begin
          observe(EV_SAMPLE);
          samples_seen++;
          if (samples_seen == bits_target) stop_req = 1'b1;
        end
        if (stop_stb) begin
          observe(EV_STOP);
          stop_req = 1'b0;
          stop_tk = tk;
          if (chain_start) start_req = 1'b1;
        end
        if (stretch_left > 0) stretch_left--;
        tk++;
      end
    end else begin
      scl_pad_in = !scl_drive_low;
    end
  end

  task automatic set_cfg(int cdf, int scgd, int comp, int setup);
    clk_div_cfg     = 9'((scgd << 3) | cdf);
    rise_fall_comp  = 4'(comp);
    first_bit_setup = 4'(setup);
  endtask

  task automatic wait_drain(int cdf, int hi);
    int guard = 0;
    while (exp_q.size() != 0 && guard < 20000) begin
      @(negedge clk); guard++;
    end
    check(exp_q.size() == 0, "R8", "events left", exp_q.size(), 0);
    repeat ((hi + 2) * (cdf + 1) + 4) @(negedge clk);
    check(!scl_drive_low, "R9", "SCL released after stop", scl_drive_low, 0);
  endtask

  task automatic run_xfer(int cdf, int scgd, int comp, int setup, int nbits, int sbit, int slen);
    int p;
    p = 20 + scgd * 8 + comp;
    set_cfg(cdf, scgd, comp, setup);
    bits_target = nbits; stretch_bit = sbit; stretch_len = slen;
    queue_xfer(scgd, comp, setup, nbits, sbit, slen);
    @(negedge clk);
    start_req = 1'b1;
    wait_drain(cdf, (p + 1) / 2);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int cnt;
    set_cfg(1, 0, 2, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!scl_drive_low && !start_stb && !stop_stb, "R9", "reset state",
          {scl_drive_low, start_stb, stop_stb}, 0);

    // R1: prescaler spacing, and R9: nothing happens while idle
    foreach (cnt_list[i]) ;
    for (int c = 0; c < 8; c += 3) begin
      int strobes = 0;
      clk_div_cfg = 9'(c);
      @(negedge clk);
      cnt = 0;
      repeat (8 * (c + 1)) begin
        @(negedge clk);
        if (ick_en) cnt++;
        if (scl_drive_low || sda_change_stb || sda_sample_stb || start_stb || stop_stb)
          strobes++;
      end
      check(cnt == 8, "R1", $sformatf("tick count cdf=%0d", c), cnt, 8);
      check(strobes == 0, "R9", "idle activity", strobes, 0);
    end

    mon_en = 1'b1;
    // Even period, smallest setup
    run_xfer(1, 0, 2, 0, 3, -1, 0);
    // Odd period, largest setup, stretch in second bit
    run_xfer(0, 1, 5, 15, 2, 1, 5);
    // Back-to-back: second start requested right at the stop strobe
    begin
      set_cfg(0, 0, 0, 3);
      bits_target = 1; stretch_bit = -1; stretch_len = 0;
      queue_xfer(0, 0, 3, 1, -1, 0);
      queue_xfer(0, 0, 3, 1, -1, 0);
      chain_gap = 10 + 1;        // R8: H ticks free after stop, then idle tick
      @(negedge clk);
      start_req = 1'b1;
      wait (samples_seen == 1);
      chain_start = 1'b1;
      wait_drain(0, 10);
      check(!chain_start, "R8", "chained start seen", chain_start, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  int cnt_list[1];

endmodule